// File: doc/BRIEF.md
# Indirect Serial Flash Read Engine

This block carries out a bulk read from a serial NOR flash on behalf of a host. The host programs the command shape through a small register port: opcode, data lane width, an optional mode byte with its value, a dummy clock count, the address width, the start address and the number of bytes. It then sets a start bit. The engine lowers chip select and shifts out the opcode and address on a single lane. If enabled, it sends the mode byte next, then idles for the dummy clocks. It then captures the returned data on one, two or four lanes, packs it into 32-bit words and places them in a local word buffer.

The host drains the buffer through a pop port and watches the fill level, which is given in words. When the buffer is full, the engine stops the serial clock until space frees up, so no data is lost however slowly the host drains. At the end of a transfer a sticky done flag is set, which the host clears by writing one to it. A cancel bit stops a transfer at once and discards whatever is buffered.

The serial clock runs at half the system clock. The engine drives data while the serial clock is low, and the flash's data is taken at the rising edge.

Top module: `ifr_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, dq_oe is 0, fill_level is 0, and the control register (offset 5) reads 0.
- R2: After start, the engine first shifts the opcode and then the address out on dq_out[0], most significant bit first, one bit per sclk rising edge. dq_oe is 4'b0001 throughout this phase. The address-size register (offset 2) holds the byte count minus one: the value 3 sends four address bytes, and any other value sends the low three bytes.
- R3: When bit 20 of the instruction register (offset 0) is 1, the 8-bit value in the mode register (offset 1) is shifted out after the address and before the dummy clocks. When bit 20 is 0, no mode byte is sent.
- R4: After the command, the engine issues exactly as many sclk cycles as the dummy field (instruction bits 28..24), with dq_oe equal to 0.
- R5: Instruction bits 17..16 select the data lanes, and each received byte arrives most significant bit first. 0 selects one lane on dq_in[1], giving 8 clocks per byte. 1 selects two lanes with the upper bit on dq_in[1], giving 4 clocks per byte. 2 or 3 selects four lanes with the upper bit on dq_in[3], giving 2 clocks per byte. The total number of data clocks is the byte count times the clocks per byte.
- R6: Received bytes are packed little-endian: the first byte of each group of four lands in bits 7..0. A final partial word has zeros in its unfilled upper bytes. The buffer head appears on pop_data.
- R7: fill_level, and bits 15..0 of offset 6, give the number of buffered words. This number never exceeds the buffer depth.
- R8: While the data phase has a full buffer, sclk stays low. It resumes once the host pops, and the data stream continues without loss.
- R9: After the last data clock, cs_n rises, the busy bit (control bit 2) falls and done (control bit 5) is set. Writing 1 to control bit 5 clears done, and a start also clears it.
- R10: Writing 1 to cancel (control bit 1) ends any transfer on the next cycle. cs_n goes high, the buffer empties and done is left clear.
- R11: While busy, writes to the configuration registers (offsets 0 to 4) and further starts (control bit 0) are ignored.
- R12: A byte count of 0 runs the command and dummy phases, then finishes with done set and no data clocks.
- R13: A pop while the buffer is empty is ignored and leaves fill_level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pop | input | 1 | Remove the buffer head word |
| pop_data | output | 32 | Buffer head word |
| fill_level | output | 16 | Buffered words |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Flash chip select, active low |
| dq_out | output | 4 | Serial data out |
| dq_oe | output | 4 | Serial data output enables |
| dq_in | input | 4 | Serial data in |

## Verification
The checker watches several properties on every cycle. Output enables must stay on lane 0 only, and the fill level must stay within the buffer depth. sclk must stay low whenever chip select is high, and also whenever the data phase faces a full buffer. A cancel must release chip select and empty the buffer on the next cycle, and done may only rise while the bus is idle.

Other behaviours can only be shown by the bench's scenarios, using a behavioural flash model. These are the exact command bit string, the dummy and data clock counts for each lane width, byte packing with zero padding, register values ignored while busy, and recovery after cancel. The bench sweeps lane width, byte counts 0 to 9, mode byte and address width.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  // register word offsets
  localparam logic [2:0] OFS_INSTR = 3'd0;
  localparam logic [2:0] OFS_MODE  = 3'd1;
  localparam logic [2:0] OFS_ASIZE = 3'd2;
  localparam logic [2:0] OFS_ADDR  = 3'd3;
  localparam logic [2:0] OFS_COUNT = 3'd4;
  localparam logic [2:0] OFS_CTRL  = 3'd5;
  localparam logic [2:0] OFS_LEVEL = 3'd6;

  // control bit positions
  localparam int CB_START  = 0;
  localparam int CB_CANCEL = 1;
  localparam int CB_BUSY   = 2;
  localparam int CB_DONE   = 5;

  localparam int CMD_W = 48;  // opcode + up to 4 address bytes + mode byte
  localparam int CNT_W = 6;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CMD,
    SEQ_DUMMY,
    SEQ_DATA
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic [1:0]  lanes;
    logic        mode_on;
    logic [4:0]  dummy;
    logic [7:0]  mode_val;
    logic        addr4;
    logic [31:0] addr;
  } rd_cfg_t;

endpackage

// File: rtl/ifr_fifo.sv
module ifr_fifo #(
  parameter int DEPTH = 4,   // power of two
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [LW-1:0] FULL_V = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          wr_en, rd_en;

  assign full  = (cnt == FULL_V);
  assign wr_en = push && !full && !flush;
  assign rd_en = pop && (cnt != '0) && !flush;
  assign head  = mem[rp];
  assign level = cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      if (wr_en && !rd_en)      cnt <= cnt + 1'b1;
      else if (rd_en && !wr_en) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ifr_pack.sv
module ifr_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        clear,
  input  logic [31:0] total,
  input  logic [1:0]  lanes,
  input  logic        smp,
  input  logic [3:0]  din,
  output logic        push,
  output logic [31:0] word,
  output logic        left_zero
);
  logic [31:0] left_q, left_n;
  logic [7:0]  bsh_q, bsh_n, nb;
  logic [2:0]  bcnt_q, bcnt_n, last_clk;
  logic [1:0]  widx_q, widx_n;
  logic [31:0] wacc_q, wacc_n, wnew, word_n;
  logic        push_n;

  always_comb begin
    unique case (lanes)
      2'd0:    begin nb = {bsh_q[6:0], din[1]};   last_clk = 3'd7; end
      2'd1:    begin nb = {bsh_q[5:0], din[1:0]}; last_clk = 3'd3; end
      default: begin nb = {bsh_q[3:0], din};      last_clk = 3'd1; end
    endcase
  end

  assign wnew = wacc_q | ({24'h0, nb} << {widx_q, 3'b000});

  always_comb begin
    left_n = left_q;
    bsh_n  = bsh_q;
    bcnt_n = bcnt_q;
    widx_n = widx_q;
    wacc_n = wacc_q;
    word_n = word;
    push_n = 1'b0;
    if (clear || load) begin
      left_n = clear ? 32'd0 : total;
      bcnt_n = '0;
      widx_n = '0;
      wacc_n = '0;
    end else if (smp) begin
      bsh_n = nb;
      if (bcnt_q == last_clk) begin
        bcnt_n = '0;
        left_n = left_q - 32'd1;
        if (widx_q == 2'd3 || left_q == 32'd1) begin
          push_n = 1'b1;
          word_n = wnew;
          wacc_n = '0;
          widx_n = '0;
        end else begin
          wacc_n = wnew;
          widx_n = widx_q + 2'd1;
        end
      end else begin
        bcnt_n = bcnt_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      bsh_q  <= '0;
      bcnt_q <= '0;
      widx_q <= '0;
      wacc_q <= '0;
      word   <= '0;
      push   <= 1'b0;
    end else begin
      left_q <= left_n;
      bsh_q  <= bsh_n;
      bcnt_q <= bcnt_n;
      widx_q <= widx_n;
      wacc_q <= wacc_n;
      word   <= word_n;
      push   <= push_n;
    end
  end

  assign left_zero = (left_q == 32'd0);
endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go,
  input  logic    abort,
  input  rd_cfg_t cfg,
  input  logic    buf_full,
  input  logic    data_zero,
  output logic    sclk,
  output logic    cs_n,
  output logic    dq0,
  output logic    oe0,
  output logic    smp,
  output logic    fin,
  output logic    busy,
  output logic    in_data
);
  seq_state_e        st_q, st_n;
  logic              sclk_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cmd_len;
  logic [CMD_W-1:0]  sh_q, sh_n, cmd_word;
  logic              want_data;

  assign cmd_len  = CNT_W'(32) + (cfg.addr4 ? CNT_W'(8) : '0) + (cfg.mode_on ? CNT_W'(8) : '0);
  assign cmd_word = cfg.addr4 ? {cfg.opcode, cfg.addr, cfg.mode_val}
                              : {cfg.opcode, cfg.addr[23:0], cfg.mode_val, 8'h00};

  always_comb begin
    st_n      = st_q;
    sclk_n    = sclk;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    fin       = 1'b0;
    smp       = 1'b0;
    want_data = 1'b0;
    if (st_q == SEQ_IDLE) begin
      if (go) begin
        st_n   = SEQ_CMD;
        sclk_n = 1'b0;
        cnt_n  = cmd_len - 1'b1;
        sh_n   = cmd_word;
      end
    end else if (abort) begin
      st_n   = SEQ_IDLE;
      sclk_n = 1'b0;
    end else if (!sclk) begin
      if (!(st_q == SEQ_DATA && buf_full)) begin
        sclk_n = 1'b1;
        smp    = (st_q == SEQ_DATA);
      end
    end else begin
      sclk_n = 1'b0;
      unique case (st_q)
        SEQ_CMD: begin
          sh_n = sh_q << 1;
          if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
          else if (cfg.dummy != '0) begin
            st_n  = SEQ_DUMMY;
            cnt_n = {1'b0, cfg.dummy} - 1'b1;
          end else want_data = 1'b1;
        end
        SEQ_DUMMY: begin
          if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
          else want_data = 1'b1;
        end
        default: want_data = 1'b1;
      endcase
      if (want_data) begin
        if (data_zero) begin
          st_n = SEQ_IDLE;
          fin  = 1'b1;
        end else st_n = SEQ_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      sclk  <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_n;
      sclk  <= sclk_n;
      cnt_q <= cnt_n;
      sh_q  <= sh_n;
    end
  end

  assign cs_n    = (st_q == SEQ_IDLE);
  assign busy    = !cs_n;
  assign dq0     = sh_q[CMD_W-1];
  assign oe0     = (st_q == SEQ_CMD);
  assign in_data = (st_q == SEQ_DATA);
endmodule

// File: rtl/ifr_engine.sv
module ifr_engine
  import ifr_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  parameter int LVL_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        pop,
  output logic [31:0] pop_data,
  output logic [15:0] fill_level,
  output logic        sclk,
  output logic        cs_n,
  output logic [3:0]  dq_out,
  output logic [3:0]  dq_oe,
  input  logic [3:0]  dq_in
);
  localparam int LW = $clog2(BUF_WORDS+1);

  logic [7:0]  r_opc, r_mode;
  logic [1:0]  r_lanes, r_asize;
  logic        r_mode_on, done_q, done_n;
  logic [4:0]  r_dummy;
  logic [31:0] r_addr, r_count;
  rd_cfg_t     cfg;
  logic        busy, go, abort, ctrl_wr, cfg_we;
  logic        smp, fin, in_data, buf_full, left_zero, push, dq0, oe0;
  logic [31:0] word;
  logic [LW-1:0] level;

  assign ctrl_wr = reg_wr && (reg_addr == OFS_CTRL);
  assign abort   = ctrl_wr && reg_wdata[CB_CANCEL];
  assign go      = ctrl_wr && reg_wdata[CB_START] && !reg_wdata[CB_CANCEL] && !busy;
  assign cfg_we  = reg_wr && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_opc     <= '0;
      r_lanes   <= '0;
      r_mode_on <= 1'b0;
      r_dummy   <= '0;
      r_mode    <= '0;
      r_asize   <= '0;
      r_addr    <= '0;
      r_count   <= '0;
    end else if (cfg_we) begin
      unique case (reg_addr)
        OFS_INSTR: begin
          r_opc     <= reg_wdata[7:0];
          r_lanes   <= reg_wdata[17:16];
          r_mode_on <= reg_wdata[20];
          r_dummy   <= reg_wdata[28:24];
        end
        OFS_MODE:  r_mode  <= reg_wdata[7:0];
        OFS_ASIZE: r_asize <= reg_wdata[1:0];
        OFS_ADDR:  r_addr  <= reg_wdata;
        OFS_COUNT: r_count <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    done_n = done_q;
    if (abort || go) done_n = 1'b0;
    else if (fin) done_n = 1'b1;
    else if (ctrl_wr && reg_wdata[CB_DONE]) done_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign cfg = '{opcode: r_opc, lanes: r_lanes, mode_on: r_mode_on, dummy: r_dummy,
                 mode_val: r_mode, addr4: (r_asize == 2'd3), addr: r_addr};

  ifr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .cfg(cfg),
    .buf_full(buf_full), .data_zero(left_zero), .sclk(sclk), .cs_n(cs_n),
    .dq0(dq0), .oe0(oe0), .smp(smp), .fin(fin), .busy(busy), .in_data(in_data)
  );

  ifr_pack u_pack (
    .clk(clk), .rst_n(rst_n), .load(go), .clear(abort), .total(r_count),
    .lanes(r_lanes), .smp(smp), .din(dq_in), .push(push), .word(word),
    .left_zero(left_zero)
  );

  ifr_fifo #(.DEPTH(BUF_WORDS), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(abort), .push(push), .din(word),
    .pop(pop), .head(pop_data), .level(level), .full(buf_full)
  );

  assign dq_out     = {3'b000, dq0};
  assign dq_oe      = {3'b000, oe0};
  assign fill_level = 16'({{(LVL_W-LW){1'b0}}, level});

  always_comb begin
    unique case (reg_addr)
      OFS_INSTR: reg_rdata = {3'b0, r_dummy, 3'b0, r_mode_on, 2'b0, r_lanes, 8'b0, r_opc};
      OFS_MODE:  reg_rdata = {24'b0, r_mode};
      OFS_ASIZE: reg_rdata = {30'b0, r_asize};
      OFS_ADDR:  reg_rdata = r_addr;
      OFS_COUNT: reg_rdata = r_count;
      OFS_CTRL:  reg_rdata = {26'b0, done_q, 2'b0, busy, 2'b0};
      OFS_LEVEL: reg_rdata = {16'b0, fill_level};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ifr_checker.sv
module ifr_checker #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        cs_n,
  input logic [3:0]  dq_oe,
  input logic [15:0] fill_level,
  input logic        in_data,
  input logic        buf_full,
  input logic        done,
  input logic        abort
);
  AST_LANE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe[3:1] == 3'b000);  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= 16'(DEPTH));  // R7
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && buf_full && !sclk) |=> !sclk);  // R8
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);  // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cs_n && !sclk));  // R9
  AST_CANCEL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (cs_n && fill_level == 16'd0 && !done));  // R10
endmodule

bind ifr_engine ifr_checker #(.DEPTH(BUF_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq_oe(dq_oe),
  .fill_level(fill_level), .in_data(in_data), .buf_full(buf_full),
  .done(done_q), .abort(abort)
);

// File: tb/tb_ifr_engine.sv
`timescale 1ns/1ps
module tb_ifr_engine;
  localparam int DEPTH = 4;

  logic clk, rst_n, reg_wr, pop, sclk, cs_n;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, pop_data;
  logic [15:0] fill_level;
  logic [3:0] dq_out, dq_oe, dq_in;

  ifr_engine #(.BUF_WORDS(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop), .pop_data(pop_data),
    .fill_level(fill_level), .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0, fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flash model state
  int exp_pre = 1000, exp_cmdbits = 32, exp_L = 1, exp_seed = 0;
  int rises = 0, falls = 0;
  logic [63:0] cmdsh = '0;
  bit oe_bad = 0;

  function automatic int dbyte(input int k, input int seed);
    return (k * 53 + seed) & 255;
  endfunction

  function automatic logic [31:0] exp_word(input int w, input int n, input int seed);
    logic [31:0] v = '0;
    for (int b = 0; b < 4; b++)
      if (4 * w + b < n) v |= 32'(dbyte(4 * w + b, seed)) << (8 * b);
    return v;
  endfunction

  always @(negedge cs_n) begin
    rises = 0; falls = 0; cmdsh = '0; oe_bad = 0;
  end

  always @(posedge sclk) begin
    if (rises < exp_cmdbits) begin
      cmdsh = {cmdsh[62:0], dq_out[0]};
      if (dq_oe != 4'b0001) oe_bad = 1;
    end else if (dq_oe != 4'b0000) oe_bad = 1;
    rises++;
  end

  always @(negedge sclk) begin
    falls++;
    if (falls >= exp_pre) begin
      int d, cpb, b, bits;
      d = falls - exp_pre;
      cpb = 8 / exp_L;
      b = dbyte(d / cpb, exp_seed);
      bits = (b >> (8 - exp_L * ((d % cpb) + 1))) & ((1 << exp_L) - 1);
      if (exp_L == 1) dq_in = {2'b00, bits[0], 1'b0};
      else if (exp_L == 2) dq_in = {2'b00, bits[1:0]};
      else dq_in = bits[3:0];
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input int opc, input int lanes, input bit men, input int mval,
                     input int dum, input int asz, input logic [31:0] addr,
                     input int n, input int seed, input bit stall, input bit meddle);
    int nab, L, words, it, toggles;
    logic [63:0] ec;
    logic [31:0] r;
    bit stalled;
    nab = (asz == 3) ? 4 : 3;
    L = (lanes == 0) ? 1 : (lanes == 1) ? 2 : 4;
    exp_cmdbits = 8 + 8 * nab + (men ? 8 : 0);
    exp_pre = exp_cmdbits + dum;
    exp_L = L;
    exp_seed = seed;
    ec = 64'(opc);
    for (int i = nab - 1; i >= 0; i--) ec = (ec << 8) | 64'((addr >> (8 * i)) & 255);
    if (men) ec = (ec << 8) | 64'(mval);
    wr(3'd0, (32'(dum) << 24) | (32'(men) << 20) | (32'(lanes) << 16) | 32'(opc));
    wr(3'd1, 32'(mval));
    wr(3'd2, 32'(asz));
    wr(3'd3, addr);
    wr(3'd4, 32'(n));
    wr(3'd5, 32'h1);
    words = 0; it = 0; stalled = 0;
    while (!(cs_n && fill_level == 16'd0) && it < 5000) begin
      @(negedge clk);
      it++;
      pop = 1'b0;
      reg_wr = 1'b0;
      if (meddle && it == 10) begin reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0; end
      if (meddle && it == 11) begin reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h1; end
      if (stall && !stalled && fill_level == 16'(DEPTH)) begin
        stalled = 1;
        rd(3'd6, r);
        check(r == 32'(DEPTH), "R7 level register when full", r, DEPTH);
        toggles = 0;
        for (int c = 0; c < 16; c++) begin
          @(negedge clk);
          if (sclk) toggles++;
        end
        check(toggles == 0, "R8 sclk held while full", toggles, 0);
      end
      if (fill_level != 16'd0 && (!stall || stalled)) begin
        check(pop_data == exp_word(words, n, seed), "R5/R6 data word", pop_data, exp_word(words, n, seed));
        pop = 1'b1;
        words++;
      end
    end
    pop = 1'b0;
    reg_wr = 1'b0;
    check(words == (n + 3) / 4, "R6 word count", words, (n + 3) / 4);
    check(cmdsh[47:0] == ec[47:0], "R2/R3 command bits", cmdsh[47:0], ec[47:0]);
    check(!oe_bad, "R4 output enables per phase", oe_bad, 0);
    check(rises == exp_pre + n * 8 / L, "R4/R5/R12 sclk count", rises, exp_pre + n * 8 / L);
    rd(3'd5, r);
    check(r == 32'h20, "R9 done set and busy clear", r, 32'h20);
    if (stall) check(stalled, "R8 buffer reached full", stalled, 1);
    if (meddle) begin
      rd(3'd0, r);
      check(r[7:0] == 8'(opc), "R11 instruction write ignored while busy", r[7:0], opc);
    end
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pop = 1'b0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, r);
    check(cs_n && !sclk && dq_oe == 4'b0 && fill_level == 16'd0 && r == 32'h0,
          "R1 reset state", {cs_n, sclk, dq_oe, fill_level, r}, 64'h1_0_0_0000_00000000 >> 0);

    // sweep: lane width x byte count x mode byte
    for (int ln = 0; ln < 3; ln++)
      for (int n = 0; n < 10; n++)
        for (int me = 0; me < 2; me++)
          run(8'h0B + ln, ln, me[0], 8'hA0 + n, (n * 7 + ln * 3 + me) % 32,
              (n % 2) ? 3 : 2, 32'hA5C3_1E70 + 32'(n * 4099), n, n * 17 + ln + me, 0, 0);

    // R8: stall with a slow host
    run(8'h03, 0, 0, 0, 0, 2, 32'h0012_3456, 40, 91, 1, 0);
    // R11: writes and start while busy are ignored
    run(8'h6B, 2, 1, 8'h5A, 6, 3, 32'hDEAD_BEEF, 20, 7, 0, 1);

    // R9: write one to clear done
    wr(3'd5, 32'h20);
    rd(3'd5, r);
    check(r == 32'h0, "R9 done cleared by write one", r, 0);

    // R13: pop on empty buffer
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    check(fill_level == 16'd0, "R13 empty pop ignored", fill_level, 0);
    run(8'h3B, 1, 0, 0, 8, 2, 32'h0000_0100, 5, 33, 0, 0);

    // R10: cancel mid-transfer with a full buffer
    wr(3'd0, (32'd4 << 24) | (32'd2 << 16) | 32'hEB);
    wr(3'd4, 32'd64);
    exp_pre = 36; exp_cmdbits = 32; exp_L = 4;
    wr(3'd5, 32'h1);
    for (int c = 0; c < 2000 && fill_level != 16'(DEPTH); c++) @(negedge clk);
    check(fill_level == 16'(DEPTH), "R10 setup buffer filled", fill_level, DEPTH);
    wr(3'd5, 32'h2);
    rd(3'd5, r);
    check(cs_n && fill_level == 16'd0 && r == 32'h0, "R10 cancel state",
          {cs_n, fill_level, r}, {1'b1, 16'd0, 32'd0});
    run(8'hEB, 2, 1, 8'hFF, 4, 3, 32'h8000_0000, 9, 5, 0, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule